// File: doc/BRIEF.md
# 66-bit Block Boundary Acquisition

This block finds where 66-bit blocks begin in a received bit stream that arrives with no known alignment. Each cycle it takes one 66-bit word of raw line bits, the earliest received bit in bit 0. It joins the new word with the word before it and cuts a 66-bit block out of that joined window at a candidate offset. Every block starts with a 2-bit header that must contain a transition. Only that header is examined, never the payload.

While hunting, each block with a valid header adds to a run count. A block with an invalid header moves the candidate offset one bit further and clears the run. A long enough unbroken run declares lock. While locked, the block counts invalid headers inside fixed windows of blocks, and it drops back to hunting when too many invalid headers fall in one window. Downstream logic takes the aligned blocks, header in the low two bits, whenever the valid strobe is high.

Top module: `blksync_top`

## Requirements
- R1: A synchronous active-high reset clears the lock flag and the block-valid strobe, sets the candidate offset to 0, clears every counter and enters the hunt state.
- R2: A header is valid when its two bits differ (01 or 10, bit 0 being the earlier received bit). A header of 00 or 11 is invalid.
- R3: In the hunt state each accepted word whose header at the candidate offset is invalid advances the offset by one bit, from 65 back to 0, and clears the run of valid headers.
- R4: Lock is set on the clock edge that evaluates the 64th consecutive valid header at one offset in the hunt state, and not before.
- R5: The output block holds the 66 stream bits that begin at the candidate offset of the window formed by the previous word (low half) and the current word (high half); since each input word is one block long, the block output for word n is the block that began in word n-1. The header sits in block bits [1:0].
- R6: The block-valid strobe is high for one cycle after an accepted word only if lock was already set when that word was evaluated; it is never high while unlocked.
- R7: While locked, the 16th invalid header within one window of 64 locked blocks clears lock and returns the block to hunting with cleared counters; the candidate offset is kept.
- R8: After every 64 blocks evaluated while locked, the invalid-header count restarts at zero, so up to 15 invalid headers per window never drop lock.
- R9: A cycle with the input-valid low changes no state, does not shift the history, and leaves the block-valid strobe low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new raw word is present this cycle |
| in_word | input | 66 | Raw received bits, earliest bit in bit 0 |
| blk_data | output | 66 | Aligned block, header in bits [1:0] |
| blk_valid | output | 1 | blk_data holds a block taken while locked |
| blk_lock | output | 1 | Block alignment is locked |

## Verification
On every cycle the assertions check that the offset stays in range and advances by one with wraparound on each invalid hunt header, that lock only rises after a run of valid headers counted by the checker itself and only falls on an invalid header, that the valid strobe follows a locked, accepted word, and that idle cycles leave offset and lock unchanged. Only the bench scenarios can show that the run length is exactly 64, that the 15-versus-16 threshold and the window restart hold across a full window, that the block content is the one that began in the previous word at the found offset for offsets 0, 1 and 37, and that a lost lock is regained at the kept offset.

// File: rtl/blksync_pkg.sv
package blksync_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_e;

endpackage

// File: rtl/blksync_window.sv
// Keeps the previous raw word and cuts one block out of the two-word window.
module blksync_window #(
  parameter int BLK_W = 66,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_word,
  input  logic [OFF_W-1:0] offset,
  output logic [BLK_W-1:0] win_block
);

  localparam int WIN_W = 2 * BLK_W;

  logic [BLK_W-1:0] prev_q;
  logic [WIN_W-1:0] window;
  logic [WIN_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
    end else if (in_valid) begin
      prev_q <= in_word;
    end
  end

  // older word in the low half: stream order runs upward through the window
  assign window    = {in_word, prev_q};
  assign shifted   = window >> offset;
  assign win_block = shifted[BLK_W-1:0];

endmodule

// File: rtl/blksync_hdr_check.sv
// Header is good only when it shows a transition.
module blksync_hdr_check #(
  parameter int HDR_W = 2
) (
  input  logic [HDR_W-1:0] hdr,
  output logic             hdr_ok
);

  assign hdr_ok = (hdr != '0) && (hdr != '1);

endmodule

// File: rtl/blksync_fsm.sv
// Hunt / lock decision, candidate offset and the three counters.
module blksync_fsm
  import blksync_pkg::*;
#(
  parameter int BLK_W     = 66,
  parameter int OFF_W     = 7,
  parameter int LOCK_CNT  = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_BLKS  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             hdr_ok,
  output logic [OFF_W-1:0] offset,
  output logic             locked
);

  localparam int GC_W = (LOCK_CNT  > 2) ? $clog2(LOCK_CNT)  : 1;
  localparam int BC_W = (BAD_LIMIT > 2) ? $clog2(BAD_LIMIT) : 1;
  localparam int WC_W = (WIN_BLKS  > 2) ? $clog2(WIN_BLKS)  : 1;

  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(BLK_W - 1);
  localparam logic [GC_W-1:0]  GOOD_LAST = GC_W'(LOCK_CNT - 1);
  localparam logic [BC_W-1:0]  BAD_LAST  = BC_W'(BAD_LIMIT - 1);
  localparam logic [WC_W-1:0]  WIN_LAST  = WC_W'(WIN_BLKS - 1);

  sync_state_e      state_q;
  logic [OFF_W-1:0] off_q;
  logic [GC_W-1:0]  good_q;
  logic [BC_W-1:0]  bad_q;
  logic [WC_W-1:0]  win_q;
  logic [OFF_W-1:0] off_next;

  assign off_next = (off_q == OFF_LAST) ? '0 : off_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      off_q   <= '0;
      good_q  <= '0;
      bad_q   <= '0;
      win_q   <= '0;
    end else if (in_valid) begin
      case (state_q)
        ST_HUNT: begin
          if (!hdr_ok) begin
            off_q  <= off_next;
            good_q <= '0;
          end else if (good_q == GOOD_LAST) begin
            state_q <= ST_LOCK;
            good_q  <= '0;
            bad_q   <= '0;
            win_q   <= '0;
          end else begin
            good_q <= good_q + 1'b1;
          end
        end
        default: begin
          if (!hdr_ok && (bad_q == BAD_LAST)) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
            bad_q   <= '0;
            win_q   <= '0;
          end else if (win_q == WIN_LAST) begin
            win_q <= '0;
            bad_q <= '0;
          end else begin
            win_q <= win_q + 1'b1;
            if (!hdr_ok) begin
              bad_q <= bad_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign offset = off_q;
  assign locked = (state_q == ST_LOCK);

endmodule

// File: rtl/blksync_top.sv
module blksync_top #(
  parameter int BLK_W     = 66,
  parameter int HDR_W     = 2,
  parameter int LOCK_CNT  = 64,
  parameter int BAD_LIMIT = 16,
  parameter int WIN_BLKS  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BLK_W-1:0] in_word,
  output logic [BLK_W-1:0] blk_data,
  output logic             blk_valid,
  output logic             blk_lock
);

  localparam int OFF_W = $clog2(BLK_W);

  logic [OFF_W-1:0] cur_offset;
  logic [BLK_W-1:0] win_block;
  logic             hdr_ok;
  logic             fsm_lock;

  blksync_window #(
    .BLK_W (BLK_W),
    .OFF_W (OFF_W)
  ) u_window (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .offset    (cur_offset),
    .win_block (win_block)
  );

  blksync_hdr_check #(
    .HDR_W (HDR_W)
  ) u_hdr (
    .hdr    (win_block[HDR_W-1:0]),
    .hdr_ok (hdr_ok)
  );

  blksync_fsm #(
    .BLK_W     (BLK_W),
    .OFF_W     (OFF_W),
    .LOCK_CNT  (LOCK_CNT),
    .BAD_LIMIT (BAD_LIMIT),
    .WIN_BLKS  (WIN_BLKS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .hdr_ok   (hdr_ok),
    .offset   (cur_offset),
    .locked   (fsm_lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_data  <= '0;
      blk_valid <= 1'b0;
    end else begin
      blk_valid <= in_valid && fsm_lock;
      if (in_valid) begin
        blk_data <= win_block;
      end
    end
  end

  assign blk_lock = fsm_lock;

endmodule

// File: rtl/blksync_checker.sv
module blksync_checker #(
  parameter int BLK_W    = 66,
  parameter int OFF_W    = 7,
  parameter int LOCK_CNT = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             hdr_ok,
  input logic [OFF_W-1:0] offset,
  input logic             blk_valid,
  input logic             blk_lock
);

  localparam int RC_W = $clog2(LOCK_CNT + 1);

  // independent count of consecutive good hunt headers
  logic [RC_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (in_valid) begin
      if (blk_lock || !hdr_ok) run_cnt <= '0;
      else                     run_cnt <= run_cnt + 1'b1;
    end
  end

  assert_offset_range_R1: assert property (@(posedge clk) disable iff (rst)
    offset <= OFF_W'(BLK_W - 1));

  assert_slip_step_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !blk_lock && !hdr_ok) |=>
      (offset == (($past(offset) == OFF_W'(BLK_W - 1)) ? '0 : $past(offset) + 1'b1)));

  assert_lock_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(blk_lock) |-> ($past(run_cnt) == RC_W'(LOCK_CNT - 1)));

  assert_valid_needs_lock_R6: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> ($past(blk_lock) && $past(in_valid)));

  assert_loss_on_bad_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(blk_lock) |-> ($past(in_valid) && !$past(hdr_ok)));

  assert_loss_keeps_offset_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(blk_lock) |-> $stable(offset));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(offset) && $stable(blk_lock) && !blk_valid));

endmodule

bind blksync_top blksync_checker #(
  .BLK_W    (BLK_W),
  .OFF_W    (OFF_W),
  .LOCK_CNT (LOCK_CNT)
) u_blksync_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .hdr_ok    (hdr_ok),
  .offset    (cur_offset),
  .blk_valid (blk_valid),
  .blk_lock  (blk_lock)
);

// File: tb/blksync_top_bench.sv
module blksync_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [65:0] in_word = '0;
  logic [65:0] blk_data;
  logic        blk_valid;
  logic        blk_lock;

  int n_checks = 0;
  int n_fail   = 0;

  logic [131:0] pend;
  int           pend_n;
  logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;
  logic [65:0]  last_sent, prev_sent;

  always #10 clk = ~clk;

  blksync_top u_blksync_top (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .blk_data  (blk_data),
    .blk_valid (blk_valid),
    .blk_lock  (blk_lock)
  );

  task automatic check(input bit ok, input string req,
                       input logic [65:0] act, input logic [65:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic [1:0] good_hdr(input logic [63:0] s);
    return s[5] ? 2'b10 : 2'b01;
  endfunction

  // reset and start a stream with 'skew' leading zero bits
  task automatic do_reset(input int skew);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pend = '0;
    pend_n = skew;
    last_sent = '0;
    prev_sent = '0;
  endtask

  // append one block to the stream and send one 66-bit word
  task automatic push_block(input logic [1:0] hdr);
    logic [65:0]  b;
    logic [131:0] wide;
    rng = next_rng(rng);
    b = {rng, hdr};
    wide = {66'b0, b};
    pend = pend | (wide << pend_n);
    @(negedge clk);
    in_word = pend[65:0];
    in_valid = 1'b1;
    pend = pend >> 66;
    prev_sent = last_sent;
    last_sent = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic push_good();
    push_block(good_hdr(next_rng(rng)));
  endtask

  task automatic t_reset_state();
    do_reset(0);
    check(blk_lock == 1'b0, "R1 lock after reset", 66'(blk_lock), 66'd0);
    check(blk_valid == 1'b0, "R1 valid after reset", 66'(blk_valid), 66'd0);
  endtask

  // skew 1: first word is discarded by one slip, then blocks line up
  task automatic t_lock_and_loss();
    do_reset(1);
    for (int m = 0; m <= 63; m++) push_good();
    check(blk_lock == 1'b0, "R4 no lock after 63 good", 66'(blk_lock), 66'd0);
    push_block(2'b00);                       // block 64, evaluates block 63
    check(blk_lock == 1'b1, "R4 lock on 64th good", 66'(blk_lock), 66'd1);
    check(blk_valid == 1'b0, "R6 no valid on locking word", 66'(blk_valid), 66'd0);
    for (int m = 65; m <= 78; m++) push_block(m[0] ? 2'b11 : 2'b00);
    check(blk_valid == 1'b1, "R6 valid while locked", 66'(blk_valid), 66'd1);
    check(blk_data == prev_sent, "R5 aligned block", blk_data, prev_sent);
    push_good();                             // block 79, evaluates 15th bad
    check(blk_lock == 1'b1, "R7 15 bad keep lock", 66'(blk_lock), 66'd1);
    for (int m = 80; m <= 90; m++) push_good();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      check(blk_valid == 1'b0, "R9 idle gives no valid", 66'(blk_valid), 66'd0);
      check(blk_lock == 1'b1, "R9 idle keeps lock", 66'(blk_lock), 66'd1);
    end
    for (int m = 91; m <= 127; m++) push_good();
    check(blk_data == prev_sent, "R9 alignment kept over idle", blk_data, prev_sent);
    check(blk_data[1:0] == prev_sent[1:0], "R5 header in low bits",
          66'(blk_data[1:0]), 66'(prev_sent[1:0]));
    push_block(2'b11);                       // block 128, evaluates 127
    check(blk_lock == 1'b1, "R8 first window ends locked", 66'(blk_lock), 66'd1);
    push_block(2'b00);                       // evaluates block 128 (bad)
    check(blk_lock == 1'b1, "R8 window restart clears count", 66'(blk_lock), 66'd1);
    for (int m = 130; m <= 143; m++) push_block(2'b11);
    check(blk_lock == 1'b1, "R7 15th bad in window 2", 66'(blk_lock), 66'd1);
    push_good();                             // evaluates 16th bad (block 143)
    check(blk_lock == 1'b0, "R7 16th bad drops lock", 66'(blk_lock), 66'd0);
    for (int m = 145; m <= 207; m++) push_good();
    check(blk_valid == 1'b0, "R6 no valid while hunting", 66'(blk_valid), 66'd0);
    check(blk_lock == 1'b0, "R7 relock needs full run", 66'(blk_lock), 66'd0);
    push_good();
    check(blk_lock == 1'b1, "R7 relock at kept offset", 66'(blk_lock), 66'd1);
    push_good();
    check(blk_valid == 1'b1 && blk_data == prev_sent, "R5 block after relock",
          blk_data, prev_sent);
  endtask

  // bad header mid-hunt moves the offset off the true boundary
  task automatic t_hunt_slip();
    int tries;
    do_reset(1);
    for (int m = 0; m <= 19; m++) push_good();
    push_block(2'b11);                       // block 20, invalid (R2)
    for (int m = 21; m <= 21 + 64; m++) push_good();
    check(blk_lock == 1'b0, "R3 slip restarts hunt", 66'(blk_lock), 66'd0);
    tries = 0;
    while (!blk_lock && tries < 3000) begin
      push_good();
      tries++;
    end
    check(blk_lock == 1'b1, "R3 hunt wraps to boundary", 66'(blk_lock), 66'd1);
    push_good();
    check(blk_data == prev_sent, "R3 found boundary after wrap", blk_data, prev_sent);
  endtask

  task automatic t_acquire(input int skew, input string tag);
    int tries;
    do_reset(skew);
    tries = 0;
    while (!blk_lock && tries < 3000) begin
      push_good();
      tries++;
    end
    check(blk_lock == 1'b1, {tag, " lock found"}, 66'(blk_lock), 66'd1);
    for (int i = 0; i < 4; i++) begin
      push_good();
      check(blk_valid == 1'b1 && blk_data == prev_sent, {tag, " block content"},
            blk_data, prev_sent);
      check(blk_data[1:0] == 2'b01 || blk_data[1:0] == 2'b10, "R2 header transition",
            66'(blk_data[1:0]), 66'(prev_sent[1:0]));
    end
  endtask

  task automatic t_reset_while_locked();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    check(blk_lock == 1'b0, "R1 reset drops lock", 66'(blk_lock), 66'd0);
    check(blk_valid == 1'b0, "R1 reset clears valid", 66'(blk_valid), 66'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=150000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_lock_and_loss();
    t_hunt_slip();
    t_acquire(0, "R3 R5 skew 0");
    t_acquire(37, "R5 skew 37");
    t_reset_while_locked();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule